// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A load cycle captures a full starting address. Each later advance cycle steps the two low address bits through one of two orders. The upper bits are held at their loaded value. In the interleaved order, the low bits are the starting low bits XORed with a beat counter. In the linear order, the low bits are the starting low bits plus the beat counter, wrapping modulo four.

The order is sampled from a mode input on the load cycle, and it stays fixed until the next load. A burst controller drives `adv_ld` low to start a burst and drives it high on the cycles that follow. After the fourth beat, further advance cycles repeat the same four-address sequence. A load can be issued on any cycle and cuts short the burst in progress.

Top module: `bag_burst_addr`

## Requirements
- R1: On a rising edge with `adv_ld` low, `addr_out` becomes `start_addr` and `beat` becomes 0 from the next cycle on.
- R2: On a rising edge with `adv_ld` high, `beat` increments by one modulo 4, so the fifth beat of a burst shows the same address as the first.
- R3: With interleaved order (`mode` = 1 at load), `addr_out[1:0]` equals the loaded low bits XOR `beat`. For example, start 01 gives 01, 00, 11, 10.
- R4: With linear order (`mode` = 0 at load), `addr_out[1:0]` equals the loaded low bits plus `beat`, modulo 4. For example, start 11 gives 11, 00, 01, 10.
- R5: `mode` is sampled only on load edges; changes to it while advancing do not alter the sequence.
- R6: During advance cycles, `addr_out[AW-1:2]` keeps the value loaded with the burst.
- R7: `start_addr` is ignored on advance edges.
- R8: After reset, `addr_out` is 0 and `beat` is 0, and the order is interleaved.
- R9: A load in the middle of a burst restarts the sequence from the new address on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_ld | input | 1 | 0 = load a new start address, 1 = advance the burst |
| start_addr | input | AW | Starting address captured on load |
| mode | input | 1 | Order select at load: 1 interleaved, 0 linear |
| addr_out | output | AW | Address of the current beat |
| beat | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
The assertions assume that `adv_ld` is a defined level on every sampled edge once reset is released. They also assume that the first edge after reset is treated as a load or as an advance from the reset state, never as something undefined. The stimulus holds `adv_ld` low with `start_addr` at zero during reset and while idle, so the reset state and an idle load agree. Every other input change is applied on the falling edge.

// File: rtl/bag_pkg.sv
package bag_pkg;
    localparam int BEAT_W = 2;
    localparam int NUM_BEATS = 1 << BEAT_W;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_INTLV  = 1'b1
    } order_e;
endpackage

// File: rtl/bag_order.sv
module bag_order
    import bag_pkg::*;
(
    input  logic [BEAT_W-1:0] base_lo,
    input  logic [BEAT_W-1:0] beat_idx,
    input  order_e            order,
    output logic [BEAT_W-1:0] low_out
);
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] xor_lo;

    always_comb begin
        lin_lo  = base_lo + beat_idx;
        xor_lo  = base_lo ^ beat_idx;
        low_out = (order == ORD_INTLV) ? xor_lo : lin_lo;
    end
endmodule

// File: rtl/bag_state.sv
module bag_state
    import bag_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_ld,
    input  logic [AW-1:0]     start_addr,
    input  logic              mode,
    output logic [AW-1:0]     base_q,
    output logic [BEAT_W-1:0] beat_q,
    output order_e            order_q
);
    typedef struct packed {
        logic [AW-1:0]     base;
        logic [BEAT_W-1:0] beat;
        order_e            order;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        if (!adv_ld) begin
            st_d.base  = start_addr;
            st_d.beat  = '0;
            st_d.order = mode ? ORD_INTLV : ORD_LINEAR;
        end else begin
            st_d.beat  = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base  <= '0;
            st_q.beat  <= '0;
            st_q.order <= ORD_INTLV;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_q  = st_q.base;
    assign beat_q  = st_q.beat;
    assign order_q = st_q.order;
endmodule

// File: rtl/bag_burst_addr.sv
module bag_burst_addr
    import bag_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_ld,
    input  logic [AW-1:0]     start_addr,
    input  logic              mode,
    output logic [AW-1:0]     addr_out,
    output logic [BEAT_W-1:0] beat
);
    localparam int UW = AW - BEAT_W;

    logic [AW-1:0]     base_q;
    logic [BEAT_W-1:0] beat_q;
    order_e            order_q;
    logic [BEAT_W-1:0] low_now;

    bag_state #(.AW(AW)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_ld     (adv_ld),
        .start_addr (start_addr),
        .mode       (mode),
        .base_q     (base_q),
        .beat_q     (beat_q),
        .order_q    (order_q)
    );

    bag_order u_order (
        .base_lo  (base_q[BEAT_W-1:0]),
        .beat_idx (beat_q),
        .order    (order_q),
        .low_out  (low_now)
    );

    generate
        if (UW > 0) begin : g_upper
            assign addr_out = {base_q[AW-1:BEAT_W], low_now};
        end else begin : g_low_only
            assign addr_out = low_now;
        end
    endgenerate

    assign beat = beat_q;
endmodule

// File: rtl/bag_burst_addr_chk.sv
module bag_burst_addr_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adv_ld,
    input logic [AW-1:0] start_addr,
    input logic          mode,
    input logic [AW-1:0] addr_out,
    input logic [1:0]    beat,
    input logic          order_q
);
    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_ld |=> (addr_out == $past(start_addr) && beat == 2'd0)); // R1
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ld |=> beat == ($past(beat) + 2'd1)); // R2
    AST_INTLV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ld && order_q) |=> ((addr_out[1:0] ^ $past(addr_out[1:0])) == (beat ^ $past(beat)))); // R3
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ld && !order_q) |=> addr_out[1:0] == ($past(addr_out[1:0]) + 2'd1)); // R4
    AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ld |=> $stable(order_q)); // R5
    AST_ORDER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_ld |=> order_q == $past(mode)); // R5
    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ld |=> $stable(addr_out[AW-1:2])); // R6
endmodule

bind bag_burst_addr bag_burst_addr_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_ld     (adv_ld),
    .start_addr (start_addr),
    .mode       (mode),
    .addr_out   (addr_out),
    .beat       (beat),
    .order_q    (order_q)
);

// File: tb/tb_bag_burst_addr.sv
module tb_bag_burst_addr;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv_ld = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          mode = 1'b1;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    bt;
        string         tag;
    } exp_t;
    exp_t sb[$];

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    logic          m_mode = 1'b1;

    bag_burst_addr #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .adv_ld(adv_ld), .start_addr(start_addr),
        .mode(mode), .addr_out(addr_out), .beat(beat)
    );

    always #4 clk = ~clk;

    task automatic step(input logic adv, input logic [AW-1:0] a, input logic md, input string tag);
        exp_t e;
        logic [1:0] lo;
        @(negedge clk);
        adv_ld = adv; start_addr = a; mode = md;
        if (!adv) begin
            m_base = a; m_beat = 2'd0; m_mode = md;
        end else begin
            m_beat = m_beat + 2'd1;
        end
        lo = m_mode ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        e.addr = {m_base[AW-1:2], lo};
        e.bt = m_beat;
        e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (addr_out !== e.addr || beat !== e.bt) begin
                n_fail++;
                $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                         e.tag, addr_out, beat, e.addr, e.bt);
            end
        end
    end

    task automatic burst(input logic [AW-1:0] a, input logic md, input int advs, input string tag);
        step(1'b0, a, md, "R1");
        for (int i = 0; i < advs; i++) step(1'b1, a, md, tag);
    endtask

    initial begin
        #20000000;
        n_fail++;
        $display("FAIL watchdog: run=%0d expected completion", n_run);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (addr_out !== '0 || beat !== 2'd0) begin
            n_fail++;
            $display("FAIL R8: addr=%h beat=%0d expected addr=0 beat=0", addr_out, beat);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++)
            burst(20'hA5A50 | 20'(s), 1'b1, 5, "R3 R2");
        for (int s = 0; s < 4; s++)
            burst(20'h3C3C0 | 20'(s), 1'b0, 5, "R4 R2");
        step(1'b0, 20'h12341, 1'b1, "R1");
        step(1'b1, 20'h12341, 1'b0, "R5");
        step(1'b1, 20'h12341, 1'b0, "R5");
        step(1'b1, 20'h12341, 1'b1, "R5");
        step(1'b0, 20'hFFFF3, 1'b0, "R1");
        step(1'b1, 20'h00000, 1'b0, "R7 R6");
        step(1'b1, 20'h55555, 1'b1, "R7 R6");
        step(1'b1, 20'hAAAAA, 1'b0, "R7 R6");
        step(1'b0, 20'h0F0F2, 1'b1, "R1");
        step(1'b1, 20'h0F0F2, 1'b1, "R3");
        step(1'b0, 20'h70001, 1'b0, "R9");
        step(1'b1, 20'h70001, 1'b0, "R9 R4");
        step(1'b1, 20'h70001, 1'b0, "R9 R4");
        step(1'b0, 20'h00000, 1'b1, "R1");
        @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule